// File: doc/BRIEF.md
# Power-Management Event and Control Registers

This block sits on a simple I/O register bus. It holds the event status and event enable registers and the control register of an ACPI power-management controller. It also decodes a write-only command port that software uses to switch interrupt delivery on and off. The status flags are cleared by writing ones to them. The enable mask selects which of them drive a level-sensitive system control interrupt. A write to the control register can request soft power-off.

Each bus access is a single cycle. The access carries an address, a write or read strobe, a byte count and 16 data bits. Read data is presented during the same cycle as `rd_i`, without a register stage. Register updates take effect at the clock edge that ends the access. The error flag and the power-off request are registered pulses that are visible in the cycle after that edge. The interrupt output follows the status and enable registers one cycle later than the registers themselves.

Top module: `acpi_pm_regs`

## Requirements
- R1: After reset the status, enable and control registers all read 0x0000, and `sci_o`, `pwroff_o` and `err_o` are low.
- R2: The status register sits at address `EVT_BASE` (default 0x00). A write clears every bit written as 1 among bits 15, 10, 9, 8 and 4. Bits written as 0, and all other bits, keep their value.
- R3: The enable register sits at `EVT_BASE+2`. A write stores only bit 8 (power button) and bit 5 (global), and every other enable bit reads 0.
- R4: `sci_o` is high while any of status bits 0, 5, 8, 9 or 10 is set together with the enable bit at the same position. It changes one cycle after the register change that causes it.
- R5: Status, enable and control accept only `size_i`==2, and the command port accepts only `size_i`==1. Any other size on a mapped address changes no state, reads back 0x0000 and pulses `err_o` for one cycle after the access.
- R6: The control register sits at `CTRL_ADDR` (default 0x04). A write stores bits 12:2 from the data and keeps the current interrupt-enable bit 0. Bits 15:13 and 1 always read 0.
- R7: A control write with data bit 13 set and data bits 12:10 equal to 5 raises `pwroff_o` for exactly one cycle after the write. Any other sleep type, or bit 13 clear, gives no pulse.
- R8: A 1-byte write to the command port `CMD_ADDR` (default 0x06) of `ON_CODE` (0xA0) sets control bit 0, and a write of `OFF_CODE` (0xA1) clears it. Any other value changes nothing.
- R9: A one-cycle `pwrbtn_evt_i` sets status bit 8 only while control bit 0 is 1.
- R10: When a status write clearing bit 8 and a power-button event occur in the same cycle, bit 8 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| size_i | input | 3 | Access byte count |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle of `rd_i` |
| pwrbtn_evt_i | input | 1 | Power-button event pulse |
| sci_o | output | 1 | Level system control interrupt |
| pwroff_o | output | 1 | One-cycle soft power-off request |
| err_o | output | 1 | One-cycle pulse after a rejected access size |

## Verification
The bench targets the cases most likely to be wrong. A clear that collides with a button event must leave the bit set; a design that gives the clear priority would drop the event. Writing zeros, or ones to bits that are not clearable, must leave the status unchanged; a plain register store would wipe the flag. Control writes are checked so that the interrupt-enable bit survives an all-zero write and the sleep-enable bit never reads back. The power-off pulse must fire for sleep type 5 only and only when bit 13 is set; a loose decode would shut the system down on an all-ones write. Wrong-size accesses to each kind of register are checked to leave the contents intact, and a design that ignored the byte count would corrupt them.

// File: rtl/acpi_pm_pkg.sv
package acpi_pm_pkg;
  localparam int unsigned DW = 16;

  localparam logic [DW-1:0] STS_CLR_MASK = 16'h8710;
  localparam logic [DW-1:0] SCI_SRC_MASK = 16'h0721;
  localparam logic [DW-1:0] EN_WR_MASK   = 16'h0120;
  localparam logic [DW-1:0] CTRL_WR_MASK = 16'h1FFC;

  localparam int unsigned PWRBTN_BIT  = 8;
  localparam int unsigned SCIEN_BIT   = 0;
  localparam int unsigned SLPEN_BIT   = 13;
  localparam int unsigned SLPTYP_LSB  = 10;
  localparam logic [2:0]  SLPTYP_OFF  = 3'd5;

  localparam logic [2:0] SIZE_WORD = 3'd2;
  localparam logic [2:0] SIZE_BYTE = 3'd1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STS,
    SEL_EN,
    SEL_CTRL,
    SEL_CMD
  } reg_sel_e;
endpackage

// File: rtl/acpi_pm_decode.sv
module acpi_pm_decode
  import acpi_pm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] EVT_BASE  = 8'h00,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h06
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [2:0]        size_i,
  output reg_sel_e          sel_o,
  output logic              ok_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] EN_ADDR = EVT_BASE + ADDR_W'(2);

  reg_sel_e sel;
  logic     size_ok;
  logic     bad_q;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == EVT_BASE)       sel = SEL_STS;
    else if (addr_i == EN_ADDR)   sel = SEL_EN;
    else if (addr_i == CTRL_ADDR) sel = SEL_CTRL;
    else if (addr_i == CMD_ADDR)  sel = SEL_CMD;
  end

  always_comb begin
    unique case (sel)
      SEL_STS, SEL_EN, SEL_CTRL: size_ok = (size_i == SIZE_WORD);
      SEL_CMD:                   size_ok = (size_i == SIZE_BYTE);
      default:                   size_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bad_q <= 1'b0;
    else         bad_q <= (wr_i | rd_i) & (sel != SEL_NONE) & ~size_ok;
  end

  assign sel_o = sel;
  assign ok_o  = size_ok;
  assign err_o = bad_q;
endmodule

// File: rtl/acpi_pm_event.sv
module acpi_pm_event
  import acpi_pm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sts_we_i,
  input  logic          en_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pwrbtn_evt_i,
  input  logic          sci_en_i,
  output logic [DW-1:0] sts_o,
  output logic [DW-1:0] en_o,
  output logic          sci_o
);
  logic          set_pwrbtn;
  logic [DW-1:0] en_q;
  logic          sci_q;

  assign set_pwrbtn = pwrbtn_evt_i & sci_en_i;

  for (genvar b = 0; b < DW; b++) begin : g_sts
    localparam bit HAS_SET = (b == PWRBTN_BIT);
    logic set_b;
    logic q_b;
    assign set_b = HAS_SET ? set_pwrbtn : 1'b0;
    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q_b <= 1'b0;
      else if (set_b)                                q_b <= 1'b1;
      else if (sts_we_i && STS_CLR_MASK[b] && wdata_i[b]) q_b <= 1'b0;
    end
    assign sts_o[b] = q_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= wdata_i & EN_WR_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sci_q <= 1'b0;
    else         sci_q <= |(sts_o & en_q & SCI_SRC_MASK);
  end

  assign en_o  = en_q;
  assign sci_o = sci_q;
endmodule

// File: rtl/acpi_pm_ctrl.sv
module acpi_pm_ctrl
  import acpi_pm_pkg::*;
#(
  parameter logic [7:0] ON_CODE  = 8'hA0,
  parameter logic [7:0] OFF_CODE = 8'hA1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic          pwroff_o
);
  logic [DW-1:0] ctrl_q;
  logic          pwroff_q;
  logic          slp_req;

  assign slp_req = wdata_i[SLPEN_BIT] &&
                   (wdata_i[SLPTYP_LSB +: 3] == SLPTYP_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q <= (wdata_i & CTRL_WR_MASK) | (ctrl_q & (DW'(1) << SCIEN_BIT));
    end else if (cmd_we_i) begin
      if (wdata_i[7:0] == ON_CODE)       ctrl_q[SCIEN_BIT] <= 1'b1;
      else if (wdata_i[7:0] == OFF_CODE) ctrl_q[SCIEN_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwroff_q <= 1'b0;
    else         pwroff_q <= ctrl_we_i & slp_req;
  end

  assign ctrl_o   = ctrl_q;
  assign pwroff_o = pwroff_q;
endmodule

// File: rtl/acpi_pm_regs.sv
module acpi_pm_regs
  import acpi_pm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] EVT_BASE  = 8'h00,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h06,
  parameter logic [7:0] ON_CODE  = 8'hA0,
  parameter logic [7:0] OFF_CODE = 8'hA1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [2:0]        size_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              pwrbtn_evt_i,
  output logic              sci_o,
  output logic              pwroff_o,
  output logic              err_o
);
  reg_sel_e      sel;
  logic          acc_ok;
  logic          wr_ok;
  logic [DW-1:0] sts_w;
  logic [DW-1:0] en_w;
  logic [DW-1:0] ctrl_w;

  acpi_pm_decode #(
    .ADDR_W(ADDR_W), .EVT_BASE(EVT_BASE),
    .CTRL_ADDR(CTRL_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .size_i(size_i),
    .sel_o(sel), .ok_o(acc_ok), .err_o(err_o)
  );

  assign wr_ok = wr_i & acc_ok;

  acpi_pm_event u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sts_we_i(wr_ok && sel == SEL_STS),
    .en_we_i(wr_ok && sel == SEL_EN),
    .wdata_i(wdata_i), .pwrbtn_evt_i(pwrbtn_evt_i),
    .sci_en_i(ctrl_w[SCIEN_BIT]),
    .sts_o(sts_w), .en_o(en_w), .sci_o(sci_o)
  );

  acpi_pm_ctrl #(.ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ctrl_we_i(wr_ok && sel == SEL_CTRL),
    .cmd_we_i(wr_ok && sel == SEL_CMD),
    .wdata_i(wdata_i), .ctrl_o(ctrl_w), .pwroff_o(pwroff_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && acc_ok) begin
      unique case (sel)
        SEL_STS:  rdata_o = sts_w;
        SEL_EN:   rdata_o = en_w;
        SEL_CTRL: rdata_o = ctrl_w;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/acpi_pm_regs_chk.sv
module acpi_pm_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pwrbtn_evt_i,
  input logic        sci_o,
  input logic        pwroff_o,
  input logic        err_o,
  input logic [15:0] sts_w,
  input logic [15:0] en_w,
  input logic [15:0] ctrl_w
);
  a_r3_en_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w & 16'hFEDF) == 16'h0000);

  a_r6_ctrl_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_w & 16'hE002) == 16'h0000);

  a_r7_pwroff_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwroff_o |=> !pwroff_o);

  a_r5_err_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (en_w == $past(en_w)) && (ctrl_w == $past(ctrl_w)));

  a_r9_pwrbtn_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_w[8]) |-> $past(pwrbtn_evt_i && ctrl_w[0]));

  a_r4_sci_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sci_o) |-> $past(|(sts_w & en_w)));
endmodule

bind acpi_pm_regs acpi_pm_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwrbtn_evt_i(pwrbtn_evt_i),
  .sci_o(sci_o), .pwroff_o(pwroff_o), .err_o(err_o),
  .sts_w(sts_w), .en_w(en_w), .ctrl_w(ctrl_w)
);

// File: tb/acpi_pm_regs_test.sv
`timescale 1ns/1ps
module acpi_pm_regs_test;
  typedef struct {
    int          kind;  // 0 rdata, 1 sci, 2 pwroff, 3 err
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  size = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        evt = 1'b0;
  logic        sci, pwroff, err;

  int total = 0, bad = 0;
  bit done = 0;
  item_t sb_q[$];

  localparam logic [7:0] A_STS = 8'h00, A_EN = 8'h02, A_CTL = 8'h04, A_CMD = 8'h06;

  always #2.5 clk = ~clk;

  acpi_pm_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
    .pwrbtn_evt_i(evt), .sci_o(sci), .pwroff_o(pwroff), .err_o(err)
  );

  // monitor: pops expectations and compares against the live outputs
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      begin
        item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = rdata;
          1: act = {15'd0, sci};
          2: act = {15'd0, pwroff};
          default: act = {15'd0, err};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_out(int kind, logic [15:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    #0.1;
  endtask

  // one write; returns at the negedge after the capturing edge
  task automatic wr_acc(logic [7:0] a, logic [2:0] s, logic [15:0] d, bit with_evt = 0);
    @(negedge clk);
    addr = a; size = s; wdata = d; wr = 1'b1; evt = with_evt;
    @(negedge clk);
    wr = 1'b0; evt = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    addr = a; size = 3'd2; rd = 1'b1;
    #0.5;
    expect_out(0, exp, req);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_out(1, 16'h0, "R1");
    expect_out(2, 16'h0, "R1");
    expect_out(3, 16'h0, "R1");
    rd_chk(A_STS, 16'h0000, "R1");
    rd_chk(A_EN,  16'h0000, "R1");
    rd_chk(A_CTL, 16'h0000, "R1");

    // R9 event ignored while interrupt enable bit is 0
    pulse_evt();
    rd_chk(A_STS, 16'h0000, "R9");

    // R8 command codes
    wr_acc(A_CMD, 3'd1, 16'h0055);
    rd_chk(A_CTL, 16'h0000, "R8");
    wr_acc(A_CMD, 3'd1, 16'h00A0);
    rd_chk(A_CTL, 16'h0001, "R8");

    // R9 event now sets bit 8; R4 no interrupt without enable
    pulse_evt();
    rd_chk(A_STS, 16'h0100, "R9");
    expect_out(1, 16'h0, "R4");

    // R3 enable mask, R4 one-cycle lag
    wr_acc(A_EN, 3'd2, 16'hFFFF);
    expect_out(1, 16'h0, "R4");
    @(negedge clk);
    expect_out(1, 16'h1, "R4");
    rd_chk(A_EN, 16'h0120, "R3");

    // R2 zeros and non-target ones leave bit 8
    wr_acc(A_STS, 3'd2, 16'h0000);
    rd_chk(A_STS, 16'h0100, "R2");
    wr_acc(A_STS, 3'd2, 16'hFEFF);
    rd_chk(A_STS, 16'h0100, "R2");

    // R10 clear and event in the same cycle
    wr_acc(A_STS, 3'd2, 16'h0100, 1);
    rd_chk(A_STS, 16'h0100, "R10");

    // R2 clear, R4 deassert
    wr_acc(A_STS, 3'd2, 16'h0100);
    rd_chk(A_STS, 16'h0000, "R2");
    expect_out(1, 16'h0, "R4");

    // R5 wrong sizes
    wr_acc(A_EN, 3'd1, 16'h0000);
    expect_out(3, 16'h1, "R5");
    rd_chk(A_EN, 16'h0120, "R5");
    expect_out(3, 16'h0, "R5");
    wr_acc(A_CMD, 3'd2, 16'h00A1);
    expect_out(3, 16'h1, "R5");
    rd_chk(A_CTL, 16'h0001, "R5");
    wr_acc(A_CTL, 3'd4, 16'h3400);
    expect_out(3, 16'h1, "R5");
    expect_out(2, 16'h0, "R5");
    rd_chk(A_CTL, 16'h0001, "R5");

    // R6 control masking; R7 type 7 gives no pulse
    wr_acc(A_CTL, 3'd2, 16'hFFFF);
    expect_out(2, 16'h0, "R7");
    rd_chk(A_CTL, 16'h1FFD, "R6");
    wr_acc(A_CTL, 3'd2, 16'h0000);
    rd_chk(A_CTL, 16'h0001, "R6");

    // R7 power-off request for sleep type 5
    wr_acc(A_CTL, 3'd2, 16'h3400);
    expect_out(2, 16'h1, "R7");
    @(negedge clk);
    expect_out(2, 16'h0, "R7");
    rd_chk(A_CTL, 16'h1401, "R6");
    wr_acc(A_CTL, 3'd2, 16'h1400);
    expect_out(2, 16'h0, "R7");

    // R8 disable code
    wr_acc(A_CMD, 3'd1, 16'h00A1);
    rd_chk(A_CTL, 16'h1400, "R8");

    repeat (2) @(negedge clk);
    wait (sb_q.size() == 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule